// File: doc/BRIEF.md
# Stream cipher keystream XOR engine

This block encrypts or decrypts a byte stream of any length with the 20-round ARX stream cipher in counter mode. A start pulse captures a 256-bit key, a 96-bit nonce and a 32-bit initial block counter. The engine builds a 64-byte keystream block from these values. It then takes message bytes one at a time from a valid/ready input stream, XORs each byte with the next keystream byte, and sends the result on a valid/ready output stream. After every 64 message bytes it builds the next keystream block with the counter advanced by one.

A message ends with the byte that carries the input last flag. When that byte falls inside a block, the rest of the keystream block is thrown away and the engine returns to idle, ready for another start. XOR with the keystream is its own inverse, so one engine both encrypts and decrypts. An empty message is started with the empty flag raised, and it produces no bytes.

Top module: `chacha_stream_xor`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 0 until a message has been started and its first keystream block is ready.
- R2: The keystream block is the 20-round block function of a 16-word state. Words 0..3 hold the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Word 4+k is key_i[32k+:32]. Word 12 is the block counter. Word 13+k is nonce_i[32k+:32]. Key byte i sits at key_i[8i+:8] and nonce byte i at nonce_i[8i+:8]. Keystream byte i is bits [8*(i%4)+:8] of output word i/4. Each output word is the final state word plus the initial state word.
- R3: Output byte n of a message equals input byte n XOR keystream byte n%64 of block n/64. The first block uses ctr_i unchanged.
- R4: Each later block uses a counter one higher than the block before it. The counter wraps from 0xffffffff to 0, and key and nonce words are left unchanged.
- R5: The byte accepted with in_last_i set leaves with out_last_o set, and no other byte does. Any keystream bytes left over are discarded, and a new start is then accepted.
- R6: While out_valid_o is high and out_ready_i is low, out_data_o and out_last_o hold their values. No byte is dropped or repeated, and no byte follows the last one.
- R7: A start with start_empty_i high produces no output byte and leaves in_ready_o low.
- R8: Running an output stream back through the engine with the same key, nonce and counter returns the original bytes.
- R9: in_ready_o is low whenever no keystream block is ready, and in particular in the cycle after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a message (accepted only when idle) |
| start_empty_i | input | 1 | Qualifies start: the message has no bytes |
| key_i | input | 256 | Key, byte i at bits [8i+:8] |
| nonce_i | input | 96 | Nonce, byte i at bits [8i+:8] |
| ctr_i | input | 32 | Counter of the first block |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte is the final one |
| in_ready_o | output | 1 | Engine takes the input byte this cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Output byte is the final one |
| out_ready_i | input | 1 | Sink accepts the output byte |

## Verification
The bench builds the engine with its default of 20 rounds, so the published block-function test vector can be checked as literal bytes next to the bench's own model of the cipher. That vector tests the constant words, the key and nonce layout, and the byte order at once. Message lengths of 1, 63, 64, 65 and over 128 bytes reach the partial-block and multi-block paths. A start counter of 0xffffffff exercises the counter wrap. Random gaps on the input and random stalls on the output exercise the handshake and the hold behaviour.

// File: rtl/chacha_ks_pkg.sv
package chacha_ks_pkg;
  localparam int STATE_WORDS = 16;
  localparam int BLOCK_BYTES = 64;

  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GEN  = 2'd1,
    ST_RUN  = 2'd2
  } eng_state_e;

  function automatic word_t sigma_word(input int unsigned idx);
    case (idx)
      0:       return 32'h61707865;
      1:       return 32'h3320646e;
      2:       return 32'h79622d32;
      default: return 32'h6b206574;
    endcase
  endfunction

  function automatic word_t rotl(input word_t v, input int unsigned n);
    return (v << n) | (v >> (32 - n));
  endfunction

  // One add-rotate-xor mix of four words; result packed as {d, c, b, a}
  function automatic logic [3:0][31:0] mix4(input word_t a, input word_t b,
                                            input word_t c, input word_t d);
    word_t ta, tb, tc, td;
    ta = a + b;   td = rotl(d ^ ta, 16);
    tc = c + td;  tb = rotl(b ^ tc, 12);
    ta = ta + tb; td = rotl(td ^ ta, 8);
    tc = tc + td; tb = rotl(tb ^ tc, 7);
    return {td, tc, tb, ta};
  endfunction
endpackage

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_ks_pkg::*;
(
  input  logic [STATE_WORDS-1:0][31:0] st_i,
  input  logic                         diag_i,
  output logic [STATE_WORDS-1:0][31:0] st_o
);
  word_t col_w [STATE_WORDS];
  word_t dia_w [STATE_WORDS];

  for (genvar j = 0; j < 4; j++) begin : g_lane
    localparam int BD = 4 + ((j + 1) % 4);
    localparam int CD = 8 + ((j + 2) % 4);
    localparam int DD = 12 + ((j + 3) % 4);
    logic [3:0][31:0] qc, qd;

    assign qc = mix4(st_i[j], st_i[4+j], st_i[8+j], st_i[12+j]);
    assign qd = mix4(st_i[j], st_i[BD], st_i[CD], st_i[DD]);

    assign col_w[j]    = qc[0];
    assign col_w[4+j]  = qc[1];
    assign col_w[8+j]  = qc[2];
    assign col_w[12+j] = qc[3];

    assign dia_w[j]  = qd[0];
    assign dia_w[BD] = qd[1];
    assign dia_w[CD] = qd[2];
    assign dia_w[DD] = qd[3];
  end

  always_comb begin
    for (int k = 0; k < STATE_WORDS; k++) begin
      st_o[k] = diag_i ? dia_w[k] : col_w[k];
    end
  end
endmodule

// File: rtl/chacha_ks_core.sv
module chacha_ks_core
  import chacha_ks_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_i,
  input  logic [255:0]                 key_i,
  input  logic [95:0]                  nonce_i,
  input  logic [31:0]                  ctr_i,
  input  logic                         advance_i,
  output logic                         ks_valid_o,
  output logic [STATE_WORDS-1:0][31:0] ks_words_o
);
  localparam int RW = $clog2(ROUNDS + 1);

  logic [STATE_WORDS-1:0][31:0] init_q, x_q, fresh, stepped, rnd_out;
  logic [RW-1:0]                rnd_q;
  logic                         busy_q, done_q;

  always_comb begin
    for (int k = 0; k < 4; k++) fresh[k] = sigma_word(k);
    for (int k = 0; k < 8; k++) fresh[4+k] = key_i[32*k +: 32];
    fresh[12] = ctr_i;
    for (int k = 0; k < 3; k++) fresh[13+k] = nonce_i[32*k +: 32];
  end

  always_comb begin
    stepped     = init_q;
    stepped[12] = init_q[12] + 32'd1;
  end

  chacha_round u_round (
    .st_i   (x_q),
    .diag_i (rnd_q[0]),
    .st_o   (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      x_q    <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      init_q <= fresh;
      x_q    <= fresh;
      rnd_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (advance_i) begin
      init_q <= stepped;
      x_q    <= stepped;
      rnd_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      x_q   <= rnd_out;
      rnd_q <= rnd_q + 1'b1;
      if (rnd_q == RW'(ROUNDS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < STATE_WORDS; k++) ks_words_o[k] = x_q[k] + init_q[k];
  end
  assign ks_valid_o = done_q;

  AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rnd_q < RW'(ROUNDS))); // R2
  AST_NONCE_KEPT: assert property (@(posedge clk) disable iff (rst)
    advance_i |=> (init_q[15:13] == $past(init_q[15:13]) &&
                   init_q[11:0] == $past(init_q[11:0]))); // R4
  AST_KS_DROP: assert property (@(posedge clk) disable iff (rst)
    (load_i || advance_i) |=> !ks_valid_o); // R9
endmodule

// File: rtl/ks_byte_mux.sv
module ks_byte_mux #(
  parameter int NW = 16,
  localparam int NB = NW * 4,
  localparam int IW = $clog2(NB)
) (
  input  logic [NW-1:0][31:0] words_i,
  input  logic [IW-1:0]       idx_i,
  output logic [7:0]          byte_o
);
  logic [7:0] flat [NB];

  for (genvar w = 0; w < NW; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign flat[w*4+b] = words_i[w][8*b +: 8];
    end
  end

  assign byte_o = flat[idx_i];
endmodule

// File: rtl/chacha_stream_xor.sv
module chacha_stream_xor
  import chacha_ks_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         start_empty_i,
  input  logic [255:0] key_i,
  input  logic [95:0]  nonce_i,
  input  logic [31:0]  ctr_i,
  input  logic         in_valid_i,
  input  logic [7:0]   in_data_i,
  input  logic         in_last_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [7:0]   out_data_o,
  output logic         out_last_o,
  input  logic         out_ready_i
);
  localparam int IW = $clog2(BLOCK_BYTES);

  eng_state_e                   state_q;
  logic [IW-1:0]                idx_q;
  logic                         out_valid_q, out_last_q;
  logic [7:0]                   out_data_q;
  logic                         ks_valid;
  logic [STATE_WORDS-1:0][31:0] ks_words;
  logic [7:0]                   ks_byte;
  logic                         out_free, accept, core_load, core_adv, blk_end;

  assign out_free   = !out_valid_q || out_ready_i;
  assign in_ready_o = (state_q == ST_RUN) && out_free;
  assign accept     = in_valid_i && in_ready_o;
  assign blk_end    = (idx_q == IW'(BLOCK_BYTES - 1));
  assign core_load  = (state_q == ST_IDLE) && start_i && !start_empty_i;
  assign core_adv   = accept && !in_last_i && blk_end;

  chacha_ks_core #(.ROUNDS(ROUNDS)) u_core (
    .clk        (clk),
    .rst        (rst),
    .load_i     (core_load),
    .key_i      (key_i),
    .nonce_i    (nonce_i),
    .ctr_i      (ctr_i),
    .advance_i  (core_adv),
    .ks_valid_o (ks_valid),
    .ks_words_o (ks_words)
  );

  ks_byte_mux #(.NW(STATE_WORDS)) u_mux (
    .words_i (ks_words),
    .idx_i   (idx_q),
    .byte_o  (ks_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_last_q  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_q <= 1'b1;
        out_data_q  <= in_data_i ^ ks_byte;
        out_last_q  <= in_last_i;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end

      case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (core_load) state_q <= ST_GEN;
        end
        ST_GEN: begin
          if (ks_valid) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (accept) begin
            if (in_last_i) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else if (blk_end) begin
              state_q <= ST_GEN;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign out_last_o  = out_last_q;

  AST_NO_READY_WITHOUT_KS: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN) |-> !in_ready_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o))); // R6
  AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last_i) |=> (state_q == ST_IDLE)); // R5
  AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && start_empty_i) |=>
      (state_q == ST_IDLE && !in_ready_o)); // R7
  AST_OUT_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid_o) |-> $past(accept)); // R3
endmodule

// File: tb/chacha_stream_xor_tb_top.sv
`timescale 1ns/1ps
module chacha_stream_xor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS     = 20;
  localparam int MAXLEN     = 320;

  typedef logic [31:0] w16_t [16];
  typedef logic [7:0]  kb_t  [64];

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0, start_empty_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [95:0]  nonce_i = '0;
  logic [31:0]  ctr_i = '0;
  logic         in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [7:0]   in_data_i = '0;
  logic         in_ready_o, out_valid_o, out_last_o;
  logic [7:0]   out_data_o;
  logic         out_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] msg  [MAXLEN];
  logic [7:0] expb [MAXLEN];
  logic [7:0] got  [MAXLEN];
  logic [7:0] orig [MAXLEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  chacha_stream_xor #(.ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_empty_i(start_empty_i),
    .key_i(key_i), .nonce_i(nonce_i), .ctr_i(ctr_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic w16_t m_qr(input w16_t w, input int a, input int b,
                                input int c, input int d);
    w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 16);
    w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 12);
    w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 8);
    w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 7);
    return w;
  endfunction

  // Reference block: keystream bytes for one counter value
  function automatic kb_t model_block(input logic [255:0] k, input logic [95:0] n,
                                      input logic [31:0] c);
    w16_t s, w;
    kb_t  r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e;
    s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = c;
    for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
    w = s;
    for (int r2 = 0; r2 < ROUNDS/2; r2++) begin
      w = m_qr(w, 0, 4, 8, 12);  w = m_qr(w, 1, 5, 9, 13);
      w = m_qr(w, 2, 6, 10, 14); w = m_qr(w, 3, 7, 11, 15);
      w = m_qr(w, 0, 5, 10, 15); w = m_qr(w, 1, 6, 11, 12);
      w = m_qr(w, 2, 7, 8, 13);  w = m_qr(w, 3, 4, 9, 14);
    end
    for (int i = 0; i < 64; i++) begin
      logic [31:0] t;
      t = w[i/4] + s[i/4];
      r[i] = t[8*(i%4) +: 8];
    end
    return r;
  endfunction

  task automatic prep_expected(input int len, input logic [255:0] k,
                               input logic [95:0] n, input logic [31:0] c);
    kb_t blk;
    for (int i = 0; i < len; i++) begin
      if (i % 64 == 0) blk = model_block(k, n, c + 32'(i / 64));
      expb[i] = msg[i] ^ blk[i % 64];
    end
  endtask

  task automatic run_msg(input int len, input logic [255:0] k, input logic [95:0] n,
                         input logic [31:0] c, input int gap, input int stall,
                         input string req);
    @(negedge clk);
    start_i = 1'b1; start_empty_i = 1'b0;
    key_i = k; nonce_i = n; ctr_i = c;
    @(negedge clk);
    start_i = 1'b0;
    key_i = '0; nonce_i = '0; ctr_i = '0;
    #(CLK_PERIOD/2 - 1);
    chk(in_ready_o == 1'b0, "R9", "ready right after start", 32'(in_ready_o), 0);
    fork
      begin : drv
        int i = 0;
        while (i < len) begin
          @(negedge clk);
          in_valid_i = ($urandom_range(99) >= gap);
          in_data_i  = msg[i];
          in_last_i  = (i == len - 1);
          #(CLK_PERIOD/2 - 1);
          if (in_valid_i && in_ready_o) i++;
        end
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
      end
      begin : col
        int j = 0;
        logic pv = 1'b0;
        logic [7:0] pd = '0;
        logic pl = 1'b0;
        while (j < len) begin
          @(negedge clk);
          out_ready_i = ($urandom_range(99) >= stall);
          #(CLK_PERIOD/2 - 1);
          if (pv) begin
            chk(out_valid_o && out_data_o == pd && out_last_o == pl, "R6",
                "held output", {23'd0, out_valid_o, out_data_o}, {24'd1, pd});
          end
          pv = out_valid_o && !out_ready_i;
          pd = out_data_o; pl = out_last_o;
          if (out_valid_o && out_ready_i) begin
            chk(out_data_o == expb[j], req, $sformatf("byte %0d", j),
                32'(out_data_o), 32'(expb[j]));
            chk(out_last_o == (j == len - 1), "R5", $sformatf("last flag byte %0d", j),
                32'(out_last_o), 32'(j == len - 1));
            got[j] = out_data_o;
            j++;
          end
        end
        out_ready_i = 1'b1;
        repeat (3) begin
          @(negedge clk);
          #(CLK_PERIOD/2 - 1);
          chk(!out_valid_o, "R6", "no byte after last", 32'(out_valid_o), 0);
        end
      end
    join
  endtask

  task automatic fill_random(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [255:0] k;
    logic [95:0]  n;
    void'($urandom(32'd90210));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid_i = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", 32'(out_valid_o), 0);
    chk(in_ready_o == 1'b0, "R1", "in_ready after reset", 32'(in_ready_o), 0);
    @(negedge clk);
    in_valid_i = 1'b0;

    // Published block vector: zero message exposes the keystream
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    n = '0; n[31:24] = 8'h09; n[63:56] = 8'h4a;
    for (int i = 0; i < 64; i++) msg[i] = 8'h00;
    prep_expected(64, k, n, 32'd1);
    run_msg(64, k, n, 32'd1, 0, 0, "R2");
    chk(got[0] == 8'h10, "R2", "vector byte 0", 32'(got[0]), 32'h10);
    chk(got[1] == 8'hf1, "R2", "vector byte 1", 32'(got[1]), 32'hf1);
    chk(got[2] == 8'he7, "R2", "vector byte 2", 32'(got[2]), 32'he7);
    chk(got[3] == 8'he4, "R2", "vector byte 3", 32'(got[3]), 32'he4);

    // Length corners (R3 contents, R4 block stepping, R5 truncation)
    begin
      int lens [5] = '{1, 63, 64, 65, 200};
      foreach (lens[t]) begin
        k = rnd256(); n = {$urandom, $urandom, $urandom};
        fill_random(lens[t]);
        prep_expected(lens[t], k, n, 32'(t * 1000));
        run_msg(lens[t], k, n, 32'(t * 1000), 30, 30, (lens[t] > 64) ? "R4" : "R3");
      end
    end

    // Counter wrap across three blocks
    k = rnd256(); n = {$urandom, $urandom, $urandom};
    fill_random(150);
    prep_expected(150, k, n, 32'hffffffff);
    run_msg(150, k, n, 32'hffffffff, 10, 40, "R4");

    // Empty message
    @(negedge clk);
    start_i = 1'b1; start_empty_i = 1'b1; in_valid_i = 1'b1; out_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; start_empty_i = 1'b0;
    repeat (30) begin
      #(CLK_PERIOD/2 - 1);
      chk(!out_valid_o && !in_ready_o, "R7", "empty message activity",
          {30'd0, out_valid_o, in_ready_o}, 0);
      @(negedge clk);
    end
    in_valid_i = 1'b0;

    // Decrypt returns plaintext
    k = rnd256(); n = {$urandom, $urandom, $urandom};
    fill_random(100);
    for (int i = 0; i < 100; i++) orig[i] = msg[i];
    prep_expected(100, k, n, 32'd7);
    run_msg(100, k, n, 32'd7, 20, 20, "R3");
    for (int i = 0; i < 100; i++) begin msg[i] = got[i]; expb[i] = orig[i]; end
    run_msg(100, k, n, 32'd7, 20, 20, "R8");

    // Random messages
    for (int t = 0; t < 6; t++) begin
      int len;
      logic [31:0] c;
      len = $urandom_range(300, 1);
      c = $urandom;
      k = rnd256(); n = {$urandom, $urandom, $urandom};
      fill_random(len);
      prep_expected(len, k, n, c);
      run_msg(len, k, n, c, $urandom_range(50), $urandom_range(50), "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule